// File: doc/BRIEF.md
# Linked-Descriptor Receive Frame DMA

This block is one receive DMA channel. Software builds a chain of descriptors in memory. Each descriptor holds a pointer to the next descriptor, an info word that gives the size of every data buffer in it, and up to fifteen pointer/status pairs, one pair per data buffer. Once activated, the channel takes the words of an incoming frame stream and writes them into those buffers. When a buffer is closed, the channel writes a completion status word back into its descriptor slot. Software polls the done flag in that word, or waits for the interrupt.

A frame that does not fit in one buffer carries on into the next buffer. After the configured number of buffers in a descriptor, the channel reads that descriptor's next pointer and follows it. A next pointer equal to 1 means the chain has no more entries. The channel then parks and holds the stream back. Software can append a descriptor, rewrite the old next pointer and issue a reload. The channel then reads the pointer again and continues. Deactivation lets the frame in progress finish and then stops the channel.

Words are 32 bits wide. Memory addresses are 64 bits. The upper half of every address comes from the high head-address register. Buffer capacities are multiples of four and at least four.

Top module: `rx_chain_dma`

## Requirements
- R1: After reset the channel is inactive, `s_ready` and `irq` are low, and the state register (index 6) reads 4: bit0 active=0, bit1 parked=0, bit2 empty=1.
- R2: Accepted stream words are written in arrival order to consecutive 32-bit words, starting at the buffer's data pointer. The descriptor's buffer k pointer lies at byte offset 8+8k, and its capacity is info bits 15:0 at offset 4.
- R3: A closed buffer gets its status word written at descriptor offset 12+8k. Bits 15:0 hold the bytes written, bit16 is start-of-frame (the first word of the buffer carried `s_sof`), bit17 is end-of-frame, bit19 (done) is set, and bits 18 and 31:20 are zero.
- R4: A buffer closes when it is full, or when a word with `s_eof` arrives. A full buffer closes without end-of-frame, and the frame continues in the next buffer with its own length. On the last word, `s_tail` gives the number of bytes, with 0 meaning 4.
- R5: After the number of buffers set in bits 3:0 of the config register (index 3), where 0 counts as 1, the channel reads the descriptor's next pointer at offset 0 and fetches the descriptor it points to.
- R6: A next pointer of 0x1 parks the channel. While parked, state bit1 is set, `s_ready` stays low and no data is written.
- R7: Writing bit1 of the command register (index 2) while parked re-reads the same next pointer. If it no longer equals 0x1, the channel carries on into the descriptor it names.
- R8: A closed buffer sets the interrupt status (index 5, bit0). When config bit8 is set, only buffers that carry end-of-frame set it. `irq` equals that status ANDed with the enable (index 4, bit0). Writing 1 to status bit0 clears it.
- R9: Command bit2 deactivates the channel. A frame that is partly written is completed first, and state bit2 (empty) reads 0 while it is in progress. After that the channel goes inactive and `s_ready` stays low.
- R10: Bits 63:32 of every memory address equal the high head-address register (index 1). The first descriptor's low address comes from index 0 when command bit0 activates the channel.
- R11: Once raised, a memory request keeps its address, direction and write data unchanged until `mem_ack` completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high with s_valid |
| s_data | input | 32 | Stream word, byte 0 in bits 7:0 |
| s_sof | input | 1 | Word starts a frame |
| s_eof | input | 1 | Word ends a frame |
| s_tail | input | 2 | Valid bytes of the end-of-frame word, 0 means 4 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 64 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume that memory answers each request with exactly one `mem_ack`, and only while the request is up. They also assume that `s_tail` is meaningful only on end-of-frame words, and that the configuration and head registers stay unchanged while the channel runs. The bench memory acknowledges each request one cycle after it appears. Every descriptor has a 16-byte capacity. Registers are written only before activation, or while the channel is parked or idle, except for the command and interrupt registers.

// File: rtl/rx_chain_dma.sv
module rx_chain_dma #(
  parameter int          BLK_W     = 4,
  parameter logic [31:0] CHAIN_END = 32'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_data,
  input  logic        s_sof,
  input  logic        s_eof,
  input  logic [1:0]  s_tail,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  localparam int LEN_W = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_INFO, S_DPTR, S_FILL, S_WDATA, S_WSTAT, S_NEXT, S_PARK
  } state_t;

  state_t             st;
  logic [31:0]        head_lo, head_hi, desc, dptr, wbuf;
  logic [BLK_W-1:0]   cfg_blk, blk;
  logic               eof_only, irq_en, irq_stat;
  logic [LEN_W-1:0]   cap, fill;
  logic [2:0]         winc;
  logic               blk_sof, blk_eof, in_frame, stop_req;

  logic               cmd, do_act, do_reload, do_deact, w1c;
  logic               active_w, parked_w, wr_status;
  logic [BLK_W-1:0]   cnt_eff;
  logic [31:0]        slot_off, lo_addr;
  logic [LEN_W-1:0]   fill_nx;
  logic               blk_full, accept;

  assign cmd       = reg_we && reg_addr == 3'd2;
  assign do_act    = cmd && reg_wdata[0];
  assign do_reload = cmd && reg_wdata[1];
  assign do_deact  = cmd && reg_wdata[2];
  assign w1c       = reg_we && reg_addr == 3'd5 && reg_wdata[0];

  assign active_w  = st != S_IDLE;
  assign parked_w  = st == S_PARK;
  assign wr_status = st == S_WSTAT;
  assign cnt_eff   = (cfg_blk == '0) ? BLK_W'(1) : cfg_blk;
  assign slot_off  = 32'({blk, 3'b000});
  assign fill_nx   = fill + LEN_W'(winc);
  assign blk_full  = ({1'b0, fill_nx} + 17'd4) > {1'b0, cap};

  assign s_ready = (st == S_FILL) && !(stop_req && !in_frame);
  assign accept  = s_valid && s_ready;
  assign irq     = irq_stat && irq_en;

  assign mem_req = st inside {S_INFO, S_DPTR, S_WDATA, S_WSTAT, S_NEXT};
  assign mem_we  = st == S_WDATA || wr_status;

  always_comb begin
    case (st)
      S_INFO:  lo_addr = desc + 32'd4;
      S_DPTR:  lo_addr = desc + 32'd8 + slot_off;
      S_WDATA: lo_addr = dptr + 32'(fill);
      S_WSTAT: lo_addr = desc + 32'd12 + slot_off;
      default: lo_addr = desc;
    endcase
  end
  assign mem_addr  = {head_hi, lo_addr};
  assign mem_wdata = wr_status ? {12'h000, 1'b1, 1'b0, blk_eof, blk_sof, fill} : wbuf;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = head_lo;
      3'd1:    reg_rdata = head_hi;
      3'd3:    reg_rdata = {23'd0, eof_only, 8'(cfg_blk)};
      3'd4:    reg_rdata = {31'd0, irq_en};
      3'd5:    reg_rdata = {31'd0, irq_stat};
      3'd6:    reg_rdata = {29'd0, !in_frame, parked_w, active_w};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      head_lo <= '0; head_hi <= '0; desc <= '0; dptr <= '0; wbuf <= '0;
      cfg_blk <= '0; blk <= '0; eof_only <= 1'b0; irq_en <= 1'b0; irq_stat <= 1'b0;
      cap <= '0; fill <= '0; winc <= '0;
      blk_sof <= 1'b0; blk_eof <= 1'b0; in_frame <= 1'b0; stop_req <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: head_lo <= reg_wdata;
          3'd1: head_hi <= reg_wdata;
          3'd3: begin
            cfg_blk  <= reg_wdata[BLK_W-1:0];
            eof_only <= reg_wdata[8];
          end
          3'd4: irq_en <= reg_wdata[0];
          default: ;
        endcase
      end
      if (w1c) irq_stat <= 1'b0;
      if (do_deact && active_w) stop_req <= 1'b1;

      case (st)
        S_IDLE: if (do_act) begin
          desc     <= head_lo;
          blk      <= '0;
          in_frame <= 1'b0;
          stop_req <= 1'b0;
          st       <= S_INFO;
        end
        S_INFO: if (mem_ack) begin
          cap <= mem_rdata[LEN_W-1:0];
          st  <= S_DPTR;
        end
        S_DPTR: if (mem_ack) begin
          dptr    <= mem_rdata;
          fill    <= '0;
          blk_sof <= 1'b0;
          blk_eof <= 1'b0;
          st      <= S_FILL;
        end
        S_FILL: begin
          if (stop_req && !in_frame) st <= S_IDLE;
          else if (accept) begin
            wbuf     <= s_data;
            if (fill == '0) blk_sof <= s_sof;
            blk_eof  <= s_eof;
            winc     <= (s_eof && s_tail != 2'd0) ? {1'b0, s_tail} : 3'd4;
            in_frame <= !s_eof;
            st       <= S_WDATA;
          end
        end
        S_WDATA: if (mem_ack) begin
          fill <= fill_nx;
          st   <= (blk_eof || blk_full) ? S_WSTAT : S_FILL;
        end
        S_WSTAT: if (mem_ack) begin
          if (!eof_only || blk_eof) irq_stat <= 1'b1;
          if (stop_req && !in_frame) st <= S_IDLE;
          else if (blk + BLK_W'(1) >= cnt_eff) st <= S_NEXT;
          else begin
            blk <= blk + BLK_W'(1);
            st  <= S_DPTR;
          end
        end
        S_NEXT: if (mem_ack) begin
          if (mem_rdata == CHAIN_END) st <= S_PARK;
          else begin
            desc <= mem_rdata;
            blk  <= '0;
            st   <= S_INFO;
          end
        end
        S_PARK: begin
          if (stop_req) st <= S_IDLE;
          else if (do_reload) st <= S_NEXT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rx_chain_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] head_hi,
  input logic        wr_status,
  input logic        s_ready,
  input logic        parked,
  input logic        active,
  input logic        irq_stat
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_hi_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[63:32] == head_hi);

  assert_status_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && wr_status) |-> (mem_we && mem_wdata[19] && mem_wdata[15:0] != 16'd0 && mem_wdata[31:20] == 12'd0));

  assert_park_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> !s_ready);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !s_ready);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat) |-> $past(mem_ack && wr_status));
endmodule

bind rx_chain_dma rx_chain_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .head_hi(head_hi), .wr_status(wr_status),
  .s_ready(s_ready), .parked(parked_w), .active(active_w), .irq_stat(irq_stat)
);

// File: tb/rx_chain_dma_bench.sv
module rx_chain_dma_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] HI = 32'h5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        s_valid = 1'b0, s_ready, s_sof = 1'b0, s_eof = 1'b0;
  logic [31:0] s_data = '0;
  logic [1:0]  s_tail = '0;
  logic        mem_req, mem_we, irq;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:1023];
  logic        pk_en = 1'b0;
  logic [9:0]  pk_idx = '0;
  logic [31:0] pk_val = '0;
  int          hi_bad = 0, unstable = 0;
  logic        pend = 1'b0;
  logic [63:0] pend_addr = '0;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_chain_dma u_rx_chain_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .s_tail(s_tail), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  always @(posedge clk) begin
    if (pk_en) mem[pk_idx] <= pk_val;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      pend    <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_addr[63:32] != HI) hi_bad <= hi_bad + 1;
      end
      if (pend && (!mem_req || mem_addr != pend_addr)) unstable <= unstable + 1;
      pend      <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    pk_en = 1'b1; pk_idx = a[11:2]; pk_val = v;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, input logic sof, input logic eof,
                      input logic [1:0] tail, input int limit, output bit ok);
    @(negedge clk);
    s_data = d; s_sof = sof; s_eof = eof; s_tail = tail; s_valid = 1'b1; ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (s_ready) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (ok) begin
      @(negedge clk);
      s_valid = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd6, v);
    chk("R1 state", v, 32'd4);
    chk("R1 s_ready", {31'd0, s_ready}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_single;
    bit ok; logic [31:0] v;
    push(32'h11223344, 1'b1, 1'b0, 2'd0, 50, ok);
    push(32'h55660000, 1'b0, 1'b1, 2'd2, 50, ok);
    idle(30);
    chk("R2 word0", mem[32'h400 >> 2], 32'h11223344);
    chk("R2 word1", mem[32'h404 >> 2], 32'h55660000);
    chk("R3 status", mem[32'h10C >> 2], 32'h000B0006);
    chk("R8 irq on eof", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'd1);
    rd(3'd5, v);
    chk("R8 w1c", v, 32'd0);
  endtask

  task automatic t_span;
    bit ok; logic [31:0] v;
    for (int i = 0; i < 4; i++) push(32'hA0 + 32'(i), (i == 0), 1'b0, 2'd0, 50, ok);
    idle(30);
    chk("R4 full block status", mem[32'h114 >> 2], 32'h00090010);
    chk("R2 span last word", mem[32'h41C >> 2], 32'hA3);
    rd(3'd5, v);
    chk("R8 eof-only no irq", v, 32'd0);
    push(32'hA4, 1'b0, 1'b1, 2'd0, 50, ok);
    idle(30);
    chk("R5 next descriptor data", mem[32'h420 >> 2], 32'hA4);
    chk("R4 tail block status", mem[32'h20C >> 2], 32'h000A0004);
    chk("R8 irq after eof block", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'd1);
  endtask

  task automatic t_park;
    bit ok; logic [31:0] v;
    push(32'hC0, 1'b1, 1'b1, 2'd0, 50, ok);
    idle(30);
    chk("R3 single word status", mem[32'h214 >> 2], 32'h000B0004);
    rd(3'd6, v);
    chk("R6 parked", v, 32'd7);
    push(32'hD0, 1'b1, 1'b1, 2'd3, 20, ok);
    chk("R6 held back", {31'd0, ok}, 32'd0);
    chk("R6 nothing written", mem[32'h440 >> 2], 32'd0);
    poke(32'h300, 32'h1);
    poke(32'h304, 32'd16);
    poke(32'h308, 32'h440);
    poke(32'h310, 32'h450);
    poke(32'h200, 32'h300);
    wr(3'd2, 32'h2);
    push(32'hD0, 1'b1, 1'b1, 2'd3, 50, ok);
    chk("R7 accepted after reload", {31'd0, ok}, 32'd1);
    idle(30);
    chk("R7 data", mem[32'h440 >> 2], 32'hD0);
    chk("R7 status", mem[32'h30C >> 2], 32'h000B0003);
  endtask

  task automatic t_deact;
    bit ok; logic [31:0] v;
    push(32'hE0, 1'b1, 1'b0, 2'd0, 50, ok);
    idle(20);
    wr(3'd2, 32'h4);
    idle(10);
    rd(3'd6, v);
    chk("R9 still running mid-frame", v, 32'd1);
    push(32'hE1, 1'b0, 1'b1, 2'd0, 50, ok);
    chk("R9 frame tail accepted", {31'd0, ok}, 32'd1);
    idle(40);
    chk("R9 frame closed", mem[32'h314 >> 2], 32'h000B0008);
    rd(3'd6, v);
    chk("R9 stopped", v, 32'd4);
    chk("R9 no ready", {31'd0, s_ready}, 32'd0);
  endtask

  task automatic t_irq_gate;
    logic [31:0] v;
    wr(3'd4, 32'd0);
    rd(3'd5, v);
    chk("R8 status held", v, 32'd1);
    chk("R8 gated off", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'd1);
    chk("R8 gated on", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'd1);
    chk("R8 cleared", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    for (int i = 0; i < 288; i++) poke(32'(i) << 2, 32'd0);
    poke(32'h100, 32'h200);
    poke(32'h104, 32'd16);
    poke(32'h108, 32'h400);
    poke(32'h110, 32'h410);
    poke(32'h200, 32'h1);
    poke(32'h204, 32'd16);
    poke(32'h208, 32'h420);
    poke(32'h210, 32'h430);
    rst_n = 1'b1;
    t_reset();
    wr(3'd0, 32'h100);
    wr(3'd1, HI);
    wr(3'd3, 32'h102);
    wr(3'd4, 32'd1);
    wr(3'd2, 32'h1);
    t_single();
    t_span();
    t_park();
    t_deact();
    t_irq_gate();
    chk("R10 high address", 32'(hi_bad), 32'd0);
    chk("R11 request stable", 32'(unstable), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule